// File: doc/BRIEF.md
# Serial-to-Register Write Bridge

This block is a serial slave that turns each chip-select-framed transfer into one write on a simple register bus. The serial side has a clock, an active-low chip select and a data input. A frame carries a 16-bit register address followed by an 8-bit data value, both most-significant bit first. The data input is sampled on each rising serial clock edge while chip select is low.

All three serial inputs are brought into the system clock domain through two-flop synchronizers, and their edges are found inside that domain. The system clock must run at least four times faster than the serial clock. When chip select returns high after exactly 24 received bits, the bridge drives the address and data on the register bus and raises a write strobe for one system clock. A frame of any other length is dropped without a write. The address and data outputs then keep their values until the next good frame completes.

Top module: `spiwr_bridge`

## Requirements
- R1: During and just after a synchronous reset, `reg_we` is 0 and `reg_addr` and `reg_wdata` are 0.
- R2: In a 24-bit frame, the first 16 bits form `reg_addr` and the last 8 bits form `reg_wdata`, each sent most-significant bit first.
- R3: The data input is sampled only at rising edges of the serial clock. A change of the data input while the serial clock is high has no effect on the written value.
- R4: Each good frame produces exactly one `reg_we` pulse, one system clock wide, a few system clocks after chip select rises.
- R5: A frame of fewer than 24 bits (tested with 23) produces no write and leaves `reg_addr` and `reg_wdata` unchanged.
- R6: A frame of more than 24 bits (tested with 25) produces no write and leaves `reg_addr` and `reg_wdata` unchanged.
- R7: A frame that follows a dropped frame is decoded from bit 0.
- R8: `reg_addr` and `reg_wdata` change only in the cycle in which `reg_we` is high.
- R9: Serial clock edges while chip select is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, idles low |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data in |
| reg_addr | output | AW (16) | Register bus address |
| reg_wdata | output | DW (8) | Register bus write data |
| reg_we | output | 1 | One-cycle write strobe |

## Verification
A bit counter in the wrong state shows up at the ports within about three system clocks of chip select rising. Either an expected strobe is missing, or a strobe appears after a short or long frame. A shift register that loses or gains a bit, or that starts from stale contents, shows up in the same cycle as the strobe, as an address or data value that is rotated or corrupted. The bench therefore runs good frames with varied bit patterns, frames one bit short and one bit long, data glitches during the clock-high phase and serial clock activity while the bridge is idle. After each of these it checks the strobe count, the strobe width and the bus values.

// File: rtl/spiwr_pkg.sv
package spiwr_pkg;
  // Per-cycle serial events, decoded in the system clock domain
  typedef struct packed {
    logic clk_rise;   // serial clock rising edge seen this cycle
    logic sel_rise;   // chip select deasserted this cycle (end of frame)
    logic frame_on;   // chip select currently asserted
    logic din;        // synchronized serial data
  } spiwr_evt_t;

  localparam int unsigned SYNC_W = 3;  // {din, sel_n, clk}
endpackage

// File: rtl/spiwr_sync.sv
module spiwr_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/spiwr_edges.sv
module spiwr_edges
  import spiwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       s_clk,
  input  logic       s_sel_n,
  input  logic       s_din,
  output spiwr_evt_t evt
);
  logic clk_prev;
  logic sel_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev <= 1'b0;
      sel_prev <= 1'b1;
    end else begin
      clk_prev <= s_clk;
      sel_prev <= s_sel_n;
    end
  end

  always_comb begin
    evt.clk_rise = s_clk & ~clk_prev;
    evt.sel_rise = s_sel_n & ~sel_prev;
    evt.frame_on = ~s_sel_n;
    evt.din      = s_din;
  end
endmodule

// File: rtl/spiwr_frame.sv
module spiwr_frame
  import spiwr_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  localparam int unsigned TOTAL = AW + DW,
  localparam int unsigned CW = $clog2(TOTAL + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  spiwr_evt_t       evt,
  output logic [CW-1:0]    bit_cnt,
  output logic [TOTAL-1:0] shreg
);
  localparam logic [CW-1:0] CNT_SAT = CW'(TOTAL + 1);

  always_ff @(posedge clk) begin
    if (rst || !evt.frame_on) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (evt.clk_rise) begin
      shreg <= {shreg[TOTAL-2:0], evt.din};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spiwr_issue.sv
module spiwr_issue
  import spiwr_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  localparam int unsigned TOTAL = AW + DW,
  localparam int unsigned CW = $clog2(TOTAL + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  spiwr_evt_t       evt,
  input  logic [CW-1:0]    bit_cnt,
  input  logic [TOTAL-1:0] shreg,
  output logic [AW-1:0]    reg_addr,
  output logic [DW-1:0]    reg_wdata,
  output logic             reg_we
);
  localparam logic [CW-1:0] CNT_FULL = CW'(TOTAL);

  logic commit;
  assign commit = evt.sel_rise && (bit_cnt == CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
    end else begin
      reg_we <= commit;
      if (commit) begin
        reg_addr  <= shreg[TOTAL-1:DW];
        reg_wdata <= shreg[DW-1:0];
      end
    end
  end
endmodule

// File: rtl/spiwr_bridge.sv
module spiwr_bridge
  import spiwr_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TOTAL = AW + DW,
  localparam int unsigned CW = $clog2(TOTAL + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_clk,
  input  logic          ser_sel_n,
  input  logic          ser_din,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we
);
  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] sync_out;
  spiwr_evt_t        evt;
  logic [CW-1:0]     bit_cnt;
  logic [TOTAL-1:0]  shreg;
  logic              frame_on;

  assign raw_in = {ser_din, ser_sel_n, ser_clk};

  spiwr_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw_in),
    .dout(sync_out)
  );

  spiwr_edges u_edges (
    .clk    (clk),
    .rst    (rst),
    .s_clk  (sync_out[0]),
    .s_sel_n(sync_out[1]),
    .s_din  (sync_out[2]),
    .evt    (evt)
  );

  assign frame_on = evt.frame_on;

  spiwr_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .bit_cnt(bit_cnt),
    .shreg  (shreg)
  );

  spiwr_issue #(.AW(AW), .DW(DW)) u_issue (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .bit_cnt  (bit_cnt),
    .shreg    (shreg),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we)
  );
endmodule

// File: rtl/spiwr_checker.sv
module spiwr_checker #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  localparam int unsigned TOTAL = AW + DW,
  localparam int unsigned CW = $clog2(TOTAL + 2)
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [CW-1:0] bit_cnt,
  input logic          frame_on
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!reg_we && reg_addr == '0 && reg_wdata == '0));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  assert_write_needs_full_count_R4: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> ($past(bit_cnt) == CW'(TOTAL)));

  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CW'(TOTAL + 1));

  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !frame_on |=> (bit_cnt == '0));

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (rst)
    !reg_we |-> ($stable(reg_addr) && $stable(reg_wdata)));
endmodule

bind spiwr_bridge spiwr_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .bit_cnt  (bit_cnt),
  .frame_on (frame_on)
);

// File: tb/sim_spiwr_bridge.sv
`timescale 1ns/1ps
module sim_spiwr_bridge;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int HALF = 4;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_sel_n = 1'b1;
  logic ser_din = 1'b0;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic reg_we;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int wide_pulses = 0;
  logic we_prev = 1'b0;

  always #2 clk = ~clk;

  spiwr_bridge #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
    .ser_din(ser_din), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we)
  );

  always @(negedge clk) begin
    if (reg_we) pulses++;
    if (reg_we && we_prev) wide_pulses++;
    we_prev = reg_we;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Send nbits of v, MSB first from bit nbits-1; glitch flips din while clock high
  task automatic frame(input logic [31:0] v, input int nbits, input bit glitch);
    ser_sel_n = 1'b0;
    wait_clk(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_din = v[i];
      wait_clk(HALF);
      ser_clk = 1'b1;
      wait_clk(1);
      if (glitch) ser_din = ~v[i];
      wait_clk(HALF - 1);
      ser_clk = 1'b0;
    end
    wait_clk(HALF);
    ser_sel_n = 1'b1;
    ser_din = 1'b0;
    wait_clk(12);
  endtask

  task automatic t_reset();
    chk(reg_we == 1'b0, "R1 we", 32'(reg_we), 0);
    chk(reg_addr == '0, "R1 addr", 32'(reg_addr), 0);
    chk(reg_wdata == '0, "R1 data", 32'(reg_wdata), 0);
  endtask

  task automatic t_good(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit glitch);
    int p0 = pulses;
    frame({8'h0, a, d}, AW + DW, glitch);
    chk(pulses - p0 == 1, "R4 one strobe", 32'(pulses - p0), 1);
    chk(wide_pulses == 0, "R4 strobe width", 32'(wide_pulses), 0);
    chk(reg_addr == a, glitch ? "R3 addr" : "R2 addr", 32'(reg_addr), 32'(a));
    chk(reg_wdata == d, glitch ? "R3 data" : "R2 data", 32'(reg_wdata), 32'(d));
  endtask

  task automatic t_bad(input int nbits, input string req);
    int p0 = pulses;
    logic [AW-1:0] a0 = reg_addr;
    logic [DW-1:0] d0 = reg_wdata;
    frame(32'h00C3_A55A ^ 32'h0155_0F0F, nbits, 1'b0);
    chk(pulses - p0 == 0, req, 32'(pulses - p0), 0);
    chk(reg_addr == a0, "R8 addr held", 32'(reg_addr), 32'(a0));
    chk(reg_wdata == d0, "R8 data held", 32'(reg_wdata), 32'(d0));
  endtask

  task automatic t_idle_clock();
    int p0 = pulses;
    for (int i = 0; i < 5; i++) begin
      ser_din = i[0];
      ser_clk = 1'b1; wait_clk(HALF);
      ser_clk = 1'b0; wait_clk(HALF);
    end
    ser_din = 1'b0;
    wait_clk(8);
    chk(pulses - p0 == 0, "R9 no strobe when idle", 32'(pulses - p0), 0);
    t_good(16'h8001, 8'h7E, 1'b0);  // R9 following frame intact
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_clk(5);
    t_reset();
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_good(16'hA5A5, 8'h3C, 1'b0);
    t_good(16'h5A5A, 8'hC3, 1'b0);
    t_good(16'hFFFF, 8'h00, 1'b0);
    t_good(16'h0001, 8'h80, 1'b0);
    t_good(16'h1234, 8'h5B, 1'b1);   // R3 glitch during high phase
    t_bad(23, "R5 short frame");
    t_good(16'hBEEF, 8'h42, 1'b0);   // R7 restart after short frame
    t_bad(25, "R6 long frame");
    t_good(16'h0F0F, 8'hF1, 1'b0);   // R7 restart after long frame
    t_idle_clock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule